// File: doc/BRIEF.md
# Video Pixel CRC Signature Unit

This unit folds a stream of 24-bit pixels into a running 24-bit CRC signature. Software compares the signature with a known value after a frame to confirm that the display pipeline produced the expected image. It runs on the pixel clock. Its controls are an enable bit, a source-select bit and the vertical-blank signal. Each pixel path has its own valid strobe.

Two pixel streams come in. One is tapped before scaling and carries no border pixels. The other is tapped at the final output and includes border and overscan pixels. The source-select bit chooses between them in the same cycle it changes. Setting the enable bit does not start capture. The unit arms at the next rising edge of vertical blank. While the unit is disabled, the signature is held at a nonzero seed.

Top module: `vpcrc_sig_unit`

## Requirements
- R1: After a synchronous active-low reset, the signature reads 24'h000001 and the unit is unarmed.
- R2: In any cycle where enable is low, the signature at the next edge is 24'h000001. Pixels presented while the unit is disabled do not change it. A change of enable takes effect on the next clock edge, with no wait for a frame boundary.
- R3: Once enabled, the unit arms on the first cycle in which vblank is high and was low in the previous cycle. A valid pixel in that same cycle is already folded in. If vblank is already high when enable is set, the unit waits for the next low-to-high transition.
- R4: Each armed, valid cycle computes next = shl(sig) XOR pixel. shl shifts left by one. If bit 23 was 1, the result is also XORed with the polynomial parameter, whose default is 24'hC20001 (x^24+x^23+x^22+x^17+1).
- R5: The whole 24-bit pixel is one symbol. Bits 23:16, 15:8 and 7:0 all enter the same single signature.
- R6: With select = 1, the pre-scaler pixel and its valid are used. With select = 0, the final-output pixel and its valid are used. The choice is made in the same cycle as the select value.
- R7: While armed, a cycle whose chosen valid is low leaves the signature unchanged.
- R8: Clearing enable in mid-frame returns the unit to the seed and the unarmed state. After re-enable, capture waits for a fresh rising edge of vblank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_en | input | 1 | Signature enable |
| src_sel | input | 1 | 1: pre-scaler stream, 0: final-output stream |
| vblank | input | 1 | Vertical blank, high during blanking |
| pre_valid | input | 1 | Pre-scaler pixel valid |
| pre_pix | input | 24 | Pre-scaler pixel |
| fin_valid | input | 1 | Final-output pixel valid |
| fin_pix | input | 24 | Final-output pixel |
| sig | output | 24 | Current signature |

## Verification
The hardest situations to reach from the ports are the arming corner cases. The first is enabling while vblank is already high. The second is a valid pixel landing in the very cycle of the vblank rise. The third is dropping enable in mid-frame and re-enabling before the next edge. The stimulus runs directed phases that place the enable edge at each of these points. It then runs random frames with random valid gaps, holding select fixed at each value and also toggling it mid-frame. A behavioural model of the arm state and the polynomial division is compared with the signature on every clock.

// File: rtl/vpcrc_pkg.sv
// Package: shared widths and defaults for the pixel CRC signature unit.
// Assumes a 24-bit signature with one pixel per clock.
package vpcrc_pkg;
    localparam int SIG_W = 24;
    localparam logic [SIG_W-1:0] SEED_VAL = 24'h000001;
    localparam logic [SIG_W-1:0] DEF_POLY = 24'hC20001;
    typedef logic [SIG_W-1:0] sig_t;

    // One parallel step: shift left with polynomial feedback, then XOR the pixel.
    function automatic sig_t crc_next(input sig_t s, input sig_t pix, input sig_t poly);
        sig_t sh;
        sh = {s[SIG_W-2:0], 1'b0};
        if (s[SIG_W-1]) sh = sh ^ poly;
        return sh ^ pix;
    endfunction
endpackage

// File: rtl/vpcrc_src_mux.sv
// Source mux: picks the pixel stream and its valid from the select bit.
// Assumes both streams are already aligned to clk. Purely combinational.
module vpcrc_src_mux #(
    parameter int W = 24
) (
    input  logic         sel,
    input  logic         a_valid,
    input  logic [W-1:0] a_pix,
    input  logic         b_valid,
    input  logic [W-1:0] b_pix,
    output logic         o_valid,
    output logic [W-1:0] o_pix
);
    // sel=1 chooses stream a (pre-scaler), else stream b (final output)
    always_comb begin
        o_valid = sel ? a_valid : b_valid;
        o_pix   = sel ? a_pix   : b_pix;
    end
endmodule

// File: rtl/vpcrc_arm.sv
// Arm control: tracks vblank and arms capture on its first rising edge after enable.
// Assumes vblank is synchronous to clk. Dropping enable disarms at once.
module vpcrc_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic vblank,
    output logic window
);
    logic vb_q;
    logic armed;
    logic vb_rise;

    // Detect a low-to-high transition of vblank
    always_comb vb_rise = vblank & ~vb_q;

    // Capture window: enabled and armed, or arming in this very cycle
    always_comb window = en & (armed | vb_rise);

    // Delay line for vblank and the armed flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vb_q  <= 1'b0;
            armed <= 1'b0;
        end else begin
            vb_q <= vblank;
            if (!en)          armed <= 1'b0;
            else if (vb_rise) armed <= 1'b1;
        end
    end

    // R8
    arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !armed);
    // R3
    arm_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> ($past(vblank) && !$past(vb_q) && $past(en)));
endmodule

// File: rtl/vpcrc_lfsr.sv
// Signature register: seeds while disabled, steps the parallel CRC on each strobe.
// Assumes step is only asserted inside the capture window.
module vpcrc_lfsr
    import vpcrc_pkg::*;
#(
    parameter sig_t POLY = DEF_POLY,
    parameter sig_t SEED = SEED_VAL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic step,
    input  sig_t pix,
    output sig_t sig
);
    // Seed on reset or disable, otherwise fold the pixel when stepping
    always_ff @(posedge clk) begin
        if (!rst_n || !en) sig <= SEED;
        else if (step)     sig <= crc_next(sig, pix, POLY);
    end

    // R2
    seed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (sig == SEED));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !step) |=> (sig == $past(sig)));
endmodule

// File: rtl/vpcrc_sig_unit.sv
// Top: video pixel CRC signature unit. Selects a stream, arms on vblank and runs the CRC.
// Assumes all inputs are synchronous to the pixel clock; the reset is synchronous, active low.
module vpcrc_sig_unit
    import vpcrc_pkg::*;
#(
    parameter sig_t POLY = DEF_POLY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_en,
    input  logic             src_sel,
    input  logic             vblank,
    input  logic             pre_valid,
    input  logic [SIG_W-1:0] pre_pix,
    input  logic             fin_valid,
    input  logic [SIG_W-1:0] fin_pix,
    output logic [SIG_W-1:0] sig
);
    logic px_valid;
    sig_t px_data;
    logic window;
    logic step;

    vpcrc_src_mux #(.W(SIG_W)) u_mux (
        .sel(src_sel), .a_valid(pre_valid), .a_pix(pre_pix),
        .b_valid(fin_valid), .b_pix(fin_pix),
        .o_valid(px_valid), .o_pix(px_data)
    );

    vpcrc_arm u_arm (
        .clk(clk), .rst_n(rst_n), .en(sig_en), .vblank(vblank), .window(window)
    );

    // Step only on valid pixels inside the capture window
    always_comb step = window & px_valid;

    vpcrc_lfsr #(.POLY(POLY), .SEED(SEED_VAL)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .en(sig_en), .step(step), .pix(px_data), .sig(sig)
    );

    // R6
    src_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_en && (src_sel ? !pre_valid : !fin_valid)) |=> (sig == $past(sig)));
endmodule

// File: tb/sim_vpcrc_sig_unit.sv
// Bench: behavioural model of arming and polynomial division, compared every clock.
module sim_vpcrc_sig_unit;
    localparam logic [23:0] POLY = 24'hC20001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sig_en = 1'b0, src_sel = 1'b0, vblank = 1'b0;
    logic pre_valid = 1'b0, fin_valid = 1'b0;
    logic [23:0] pre_pix = '0, fin_pix = '0;
    logic [23:0] sig;

    int n_cmp = 0, n_bad = 0, n_cyc = 0;
    string tag = "R1";
    logic [23:0] m_sig = 24'h000001;
    bit m_armed = 0, m_prev_vb = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    vpcrc_sig_unit u0 (.clk(clk), .rst_n(rst_n), .sig_en(sig_en), .src_sel(src_sel),
        .vblank(vblank), .pre_valid(pre_valid), .pre_pix(pre_pix),
        .fin_valid(fin_valid), .fin_pix(fin_pix), .sig(sig));

    // Long division of (s * x) by the polynomial, then add the pixel
    function automatic logic [23:0] model_step(logic [23:0] s, logic [23:0] p);
        logic [24:0] v;
        v = {s, 1'b0};
        if (v >= 25'h1000000) v = v ^ {1'b1, POLY};
        return v[23:0] ^ p;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // One clock: update the model from the held inputs, then compare away from the edge
    task automatic cyc();
        bit use_v, rise;
        logic [23:0] use_p;
        @(posedge clk);
        n_cyc++;
        use_v = src_sel ? pre_valid : fin_valid;
        use_p = src_sel ? pre_pix : fin_pix;
        rise = vblank && !m_prev_vb;
        if (!rst_n) begin
            m_sig = 24'h000001; m_armed = 0; m_prev_vb = 0;
        end else begin
            if (!sig_en) begin
                m_sig = 24'h000001; m_armed = 0;
            end else begin
                if (rise) m_armed = 1;
                if (m_armed && use_v) m_sig = model_step(m_sig, use_p);
            end
            m_prev_vb = vblank;
        end
        @(negedge clk);
        n_cmp++;
        if (sig !== m_sig) begin
            n_bad++;
            $display("FAIL %s: sig=%h expected %h (cycle %0d)", tag, sig, m_sig, n_cyc);
        end
    endtask

    task automatic drive_pix(int pct);
        pre_valid = ($urandom % 100) < pct;
        fin_valid = ($urandom % 100) < pct;
        pre_pix = 24'($urandom);
        fin_pix = 24'($urandom);
    endtask

    // One frame: vblank period with no valid pixels, then an active period
    task automatic frame(int blank, int active, bit toggle_sel);
        vblank = 1'b1;
        pre_valid = 0; fin_valid = 0;
        for (int i = 0; i < blank; i++) cyc();
        vblank = 1'b0;
        for (int i = 0; i < active; i++) begin
            drive_pix(75);
            if (toggle_sel && (i % 17 == 0)) src_sel = ~src_sel;
            cyc();
        end
    endtask

    initial begin
        tag = "R1";
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1: reset state
        if (sig !== 24'h000001) $display("FAIL R1: sig=%h expected 000001", sig);

        // R2: disabled unit ignores pixels and vblank edges
        tag = "R2";
        for (int i = 0; i < 40; i++) begin
            drive_pix(90); vblank = (i % 10) > 6; cyc();
        end

        // R3: enable mid-active, no capture until the vblank rise
        tag = "R3";
        vblank = 0; sig_en = 1;
        for (int i = 0; i < 20; i++) begin drive_pix(90); cyc(); end
        // valid pixel on the rise cycle itself is captured
        vblank = 1; fin_valid = 1; fin_pix = 24'hA5A5A5; cyc();
        fin_valid = 0; repeat (3) cyc();
        vblank = 0;
        // enable while vblank already high: no arm until next rise
        sig_en = 0; cyc();
        vblank = 1; cyc();
        sig_en = 1;
        for (int i = 0; i < 8; i++) begin drive_pix(90); cyc(); end
        vblank = 0;
        for (int i = 0; i < 8; i++) begin drive_pix(90); cyc(); end

        // R4 / R5: single-bit pixels in each byte lane, then random frames on final stream
        tag = "R5";
        vblank = 1; pre_valid = 0; fin_valid = 0; cyc(); vblank = 0;
        src_sel = 0;
        for (int b = 0; b < 24; b++) begin
            fin_valid = 1; pre_valid = 0; fin_pix = 24'h1 << b; cyc();
        end
        tag = "R4";
        src_sel = 0;
        for (int f = 0; f < 4; f++) frame(6, 300, 0);

        // R6: pre-scaler stream, then toggling select mid-frame
        tag = "R6";
        src_sel = 1;
        for (int f = 0; f < 4; f++) frame(6, 300, 0);
        for (int f = 0; f < 3; f++) frame(6, 300, 1);

        // R7: long blanking gaps while armed
        tag = "R7";
        for (int f = 0; f < 3; f++) begin
            vblank = 1; pre_valid = 0; fin_valid = 0; repeat (4) cyc();
            vblank = 0;
            for (int i = 0; i < 200; i++) begin drive_pix(20); cyc(); end
        end

        // R8: disable mid-frame, re-enable before the next vblank edge
        tag = "R8";
        for (int i = 0; i < 30; i++) begin drive_pix(80); cyc(); end
        sig_en = 0; drive_pix(80); cyc();
        sig_en = 1;
        for (int i = 0; i < 50; i++) begin drive_pix(80); cyc(); end
        frame(5, 200, 0);
        sig_en = 0; cyc();
        if (sig !== 24'h000001) begin
            n_bad++; $display("FAIL R2: sig=%h expected 000001", sig);
        end
        n_cmp++;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: cycles=%0d expected completion", n_cyc);
        finish_run();
    end
endmodule